// File: doc/BRIEF.md
# Multi-DAC Parallel Write Sequencer

This block is the bus master for up to four byte-loaded parallel DACs. The DACs share one 8-bit data bus, a write strobe, a high-byte enable, a load line and a clear line. Each DAC's chip select comes from an external 2-bit decoder. The sequencer drives that decoder's address lines and its enable.

A host hands over 12-bit codes through a valid/ready request port. Each request carries a channel index, a gain bit and a reference-buffer select bit. For each accepted request the sequencer writes two bytes to the addressed DAC. The low byte goes first with the high-byte enable at 0. The high byte follows with the enable at 1, and it also carries the two mode bits in spare positions.

Channel writes collect in the DACs' input registers. When the host asserts commit, the sequencer issues a single shared load strobe, so every DAC updates at once. A separate request drives the shared clear line. All strobe widths and gaps are counted in clock cycles. They are derived from nanosecond parameters and rounded up.

Top module: `dac_wr_seq`

## Requirements
- R1: After reset, dac_wr_no, dac_ldac_no and dac_clr_no are 1, dac_sel_en_o and dac_hben_o are 0, and req_ready_o is 1.
- R2: Each accepted request produces exactly two write strobes to its channel. The first has dac_hben_o=0 and data = code[7:0]. The second has dac_hben_o=1 and data = {rbuf (bit 7), gain (bit 6), 2'b00 (bits 5:4), code[11:8] (bits 3:0)}.
- R3: dac_addr_o changes only when dac_sel_en_o is 0 in both that cycle and the cycle before. dac_sel_en_o is 1 throughout every write strobe.
- R4: Every write strobe is low for exactly ceil(20 ns / clock) cycles, which is 2 at 100 MHz. Between two strobes, dac_wr_no stays high for at least ceil(50 ns / clock) cycles, which is 5.
- R5: dac_data_o and dac_hben_o keep the same value in the cycle before the strobe falls, through the whole low phase, and in the cycle after it rises.
- R6: req_ready_o goes low in the cycle after an accepted request. For a plain channel write it stays low for exactly 1 + 2*(1 + 2 + 5) = 17 cycles.
- R7: dac_ldac_no never falls without a commit. A commit, whether given while idle or during a write, produces one load strobe, low for ceil(20 ns) = 2 cycles. The strobe comes only after the last write strobe has risen, and dac_wr_no is high in the cycle before it falls. A commit given in idle pulls the load line low in the cycle after the commit edge.
- R8: A commit when no channel has been written since the last load or clear produces no load strobe.
- R9: A clear request in idle, without an accepted request in the same cycle, drives dac_clr_no low for 2 cycles starting in the cycle after it. It also discards the pending channels, so a later commit produces no load strobe.
- R10: A clear request while a channel write is in progress is ignored: dac_clr_no stays high and the write completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Channel write request valid |
| req_ready_o | output | 1 | Sequencer can accept a request |
| req_chan_i | input | 2 | Target channel index |
| req_code_i | input | 12 | DAC code |
| req_gain_i | input | 1 | Output gain select for this channel |
| req_rbuf_i | input | 1 | Reference buffer select for this channel |
| commit_i | input | 1 | Issue the common load after pending writes |
| clr_req_i | input | 1 | Broadcast clear request |
| dac_data_o | output | 8 | Shared DAC data bus |
| dac_hben_o | output | 1 | High-byte enable (1 = high byte) |
| dac_wr_no | output | 1 | Shared active-low write strobe |
| dac_addr_o | output | 2 | Chip-select decoder address |
| dac_sel_en_o | output | 1 | Chip-select decoder enable |
| dac_ldac_no | output | 1 | Shared active-low load strobe |
| dac_clr_no | output | 1 | Shared active-low clear |

## Verification
All outputs are registered from the next state, so every result shows up in the cycle right after the clock edge that causes it. The load or clear line reads low at the first sample after the commit or clear edge and high again at the third. Ready reads low for exactly 17 samples after an accepting edge. The bench drives inputs and samples outputs on the falling clock edge and counts busy samples against these figures. A falling-edge monitor measures every strobe's low and high run lengths, records the byte, the high-byte enable and the address at each write rise, and compares them with values packed by a bench function from the random request.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SEL,
    ST_WRL,
    ST_GAP,
    ST_LOAD,
    ST_CLR
  } seq_st_e;

  function automatic int unsigned cyc_ceil(input int unsigned t_ps, input int unsigned clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dac_phase_timer.sv
module dac_phase_timer #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  // len_i >= 1; phase lasts len_i cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= len_i - CNT_W'(1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
  end

  assign last_o = (cnt_q == '0);
endmodule

// File: rtl/dac_byte_pack.sv
module dac_byte_pack #(
  parameter int unsigned CODE_W = 12,
  parameter int unsigned BUS_W  = 8
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic              gain_i,
  input  logic              rbuf_i,
  input  logic              hi_i,
  output logic [BUS_W-1:0]  byte_o
);
  localparam int unsigned HI_W  = CODE_W - BUS_W;
  localparam int unsigned PAD_W = BUS_W - 2 - HI_W;

  logic [BUS_W-1:0] hi_byte;

  // mode bits sit in the top two bits of the high byte
  generate
    if (PAD_W > 0) begin : g_pad
      assign hi_byte = {rbuf_i, gain_i, {PAD_W{1'b0}}, code_i[CODE_W-1:BUS_W]};
    end else begin : g_nopad
      assign hi_byte = {rbuf_i, gain_i, code_i[CODE_W-1:BUS_W]};
    end
  endgenerate

  assign byte_o = hi_i ? hi_byte : code_i[BUS_W-1:0];
endmodule

// File: rtl/dac_seq_ctrl.sv
module dac_seq_ctrl
  import dac_seq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 2,
  parameter int unsigned CODE_W   = 12,
  parameter int unsigned BUS_W    = 8,
  parameter int unsigned CNT_W    = 3,
  parameter int unsigned ADDR_CYC = 1,
  parameter int unsigned SU_CYC   = 1,
  parameter int unsigned WRL_CYC  = 2,
  parameter int unsigned GAP_CYC  = 5,
  parameter int unsigned LDAC_CYC = 2,
  parameter int unsigned CLR_CYC  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_chan_i,
  input  logic [CODE_W-1:0] req_code_i,
  input  logic              req_gain_i,
  input  logic              req_rbuf_i,
  input  logic              commit_i,
  input  logic              clr_req_i,
  output logic              req_ready_o,
  input  logic              tmr_last_i,
  output logic              tmr_load_o,
  output logic [CNT_W-1:0]  tmr_len_o,
  output logic              pk_hi_o,
  output logic [CODE_W-1:0] pk_code_o,
  output logic              pk_gain_o,
  output logic              pk_rbuf_o,
  input  logic [BUS_W-1:0]  pk_byte_i,
  output logic [BUS_W-1:0]  dac_data_o,
  output logic              dac_hben_o,
  output logic              dac_wr_no,
  output logic [ADDR_W-1:0] dac_addr_o,
  output logic              dac_sel_en_o,
  output logic              dac_ldac_no,
  output logic              dac_clr_no
);
  seq_st_e state_q, state_d;
  logic    hi_q, hi_d;
  logic    commit_q, dirty_q;
  logic    accept, idle;
  logic    in_byte_d;

  logic [CODE_W-1:0] code_q;
  logic              gain_q, rbuf_q;
  logic [ADDR_W-1:0] chan_q;

  assign idle        = (state_q == ST_IDLE);
  assign req_ready_o = idle && !commit_q;
  assign accept      = req_ready_o && req_valid_i;

  always_comb begin
    state_d    = state_q;
    hi_d       = hi_q;
    tmr_load_o = 1'b0;
    tmr_len_o  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_ADDR; hi_d = 1'b0;
          tmr_load_o = 1'b1; tmr_len_o = CNT_W'(ADDR_CYC);
        end else if (clr_req_i) begin
          state_d = ST_CLR;
          tmr_load_o = 1'b1; tmr_len_o = CNT_W'(CLR_CYC);
        end else if ((commit_q || commit_i) && dirty_q) begin
          state_d = ST_LOAD;
          tmr_load_o = 1'b1; tmr_len_o = CNT_W'(LDAC_CYC);
        end
      end
      ST_ADDR: if (tmr_last_i) begin
        state_d = ST_SEL;
        tmr_load_o = 1'b1; tmr_len_o = CNT_W'(SU_CYC);
      end
      ST_SEL: if (tmr_last_i) begin
        state_d = ST_WRL;
        tmr_load_o = 1'b1; tmr_len_o = CNT_W'(WRL_CYC);
      end
      ST_WRL: if (tmr_last_i) begin
        state_d = ST_GAP;
        tmr_load_o = 1'b1; tmr_len_o = CNT_W'(GAP_CYC);
      end
      ST_GAP: if (tmr_last_i) begin
        if (!hi_q) begin
          state_d = ST_SEL; hi_d = 1'b1;
          tmr_load_o = 1'b1; tmr_len_o = CNT_W'(SU_CYC);
        end else begin
          state_d = ST_IDLE;
        end
      end
      ST_LOAD: if (tmr_last_i) state_d = ST_IDLE;
      ST_CLR:  if (tmr_last_i) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign in_byte_d = (state_d == ST_SEL) || (state_d == ST_WRL) || (state_d == ST_GAP);
  assign pk_hi_o   = hi_d;
  assign pk_code_o = code_q;
  assign pk_gain_o = gain_q;
  assign pk_rbuf_o = rbuf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      hi_q     <= 1'b0;
      commit_q <= 1'b0;
      dirty_q  <= 1'b0;
      code_q   <= '0;
      gain_q   <= 1'b0;
      rbuf_q   <= 1'b0;
      chan_q   <= '0;
    end else begin
      state_q <= state_d;
      hi_q    <= hi_d;
      // a commit is consumed by any idle cycle that does not start a write
      commit_q <= (commit_q || commit_i) && !(idle && !accept);
      if (accept) begin
        code_q  <= req_code_i;
        gain_q  <= req_gain_i;
        rbuf_q  <= req_rbuf_i;
        chan_q  <= req_chan_i;
        dirty_q <= 1'b1;
      end else if (state_d == ST_LOAD || state_d == ST_CLR) begin
        dirty_q <= 1'b0;
      end
    end
  end

  // bus outputs registered from next state: glitch free, aligned with state_q
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dac_data_o   <= '0;
      dac_hben_o   <= 1'b0;
      dac_wr_no    <= 1'b1;
      dac_sel_en_o <= 1'b0;
      dac_ldac_no  <= 1'b1;
      dac_clr_no   <= 1'b1;
    end else begin
      if (state_d == ST_SEL && state_q != ST_SEL) dac_data_o <= pk_byte_i;
      dac_hben_o   <= in_byte_d && hi_d;
      dac_wr_no    <= (state_d != ST_WRL);
      dac_sel_en_o <= in_byte_d;
      dac_ldac_no  <= (state_d != ST_LOAD);
      dac_clr_no   <= (state_d != ST_CLR);
    end
  end

  assign dac_addr_o = chan_q;
endmodule

// File: rtl/dac_wr_seq.sv
module dac_wr_seq
  import dac_seq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 2,
  parameter int unsigned CODE_W     = 12,
  parameter int unsigned BUS_W      = 8,
  parameter int unsigned CLK_PS     = 10000,
  parameter int unsigned T_WRL_PS   = 20000,
  parameter int unsigned T_WGAP_PS  = 50000,
  parameter int unsigned T_SU_PS    = 5000,
  parameter int unsigned T_HD_PS    = 4500,
  parameter int unsigned T_LDD_PS   = 4500,
  parameter int unsigned T_LDAC_PS  = 20000,
  parameter int unsigned T_CLR_PS   = 20000,
  parameter int unsigned ADDR_CYC   = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_chan_i,
  input  logic [CODE_W-1:0] req_code_i,
  input  logic              req_gain_i,
  input  logic              req_rbuf_i,
  input  logic              commit_i,
  input  logic              clr_req_i,
  output logic [BUS_W-1:0]  dac_data_o,
  output logic              dac_hben_o,
  output logic              dac_wr_no,
  output logic [ADDR_W-1:0] dac_addr_o,
  output logic              dac_sel_en_o,
  output logic              dac_ldac_no,
  output logic              dac_clr_no
);
  localparam int unsigned WRL_CYC  = max2(1, cyc_ceil(T_WRL_PS, CLK_PS));
  localparam int unsigned SU_CYC   = max2(1, cyc_ceil(T_SU_PS, CLK_PS));
  localparam int unsigned GAP_CYC  = max2(1, max2(cyc_ceil(T_WGAP_PS, CLK_PS),
                                      max2(cyc_ceil(T_HD_PS, CLK_PS), cyc_ceil(T_LDD_PS, CLK_PS))));
  localparam int unsigned LDAC_CYC = max2(1, cyc_ceil(T_LDAC_PS, CLK_PS));
  localparam int unsigned CLR_CYC  = max2(1, cyc_ceil(T_CLR_PS, CLK_PS));
  localparam int unsigned ADR_CYC  = max2(1, ADDR_CYC);
  localparam int unsigned MAX_CYC  = max2(max2(WRL_CYC, SU_CYC), max2(max2(GAP_CYC, LDAC_CYC),
                                      max2(CLR_CYC, ADR_CYC)));
  localparam int unsigned CNT_W    = $clog2(MAX_CYC + 1);

  logic              tmr_load, tmr_last, pk_hi, pk_gain, pk_rbuf;
  logic [CNT_W-1:0]  tmr_len;
  logic [CODE_W-1:0] pk_code;
  logic [BUS_W-1:0]  pk_byte;

  dac_seq_ctrl #(
    .ADDR_W(ADDR_W), .CODE_W(CODE_W), .BUS_W(BUS_W), .CNT_W(CNT_W),
    .ADDR_CYC(ADR_CYC), .SU_CYC(SU_CYC), .WRL_CYC(WRL_CYC), .GAP_CYC(GAP_CYC),
    .LDAC_CYC(LDAC_CYC), .CLR_CYC(CLR_CYC)
  ) u_ctrl (
    .clk_i, .rst_ni,
    .req_valid_i, .req_chan_i, .req_code_i, .req_gain_i, .req_rbuf_i,
    .commit_i, .clr_req_i, .req_ready_o,
    .tmr_last_i(tmr_last), .tmr_load_o(tmr_load), .tmr_len_o(tmr_len),
    .pk_hi_o(pk_hi), .pk_code_o(pk_code), .pk_gain_o(pk_gain), .pk_rbuf_o(pk_rbuf),
    .pk_byte_i(pk_byte),
    .dac_data_o, .dac_hben_o, .dac_wr_no, .dac_addr_o, .dac_sel_en_o,
    .dac_ldac_no, .dac_clr_no
  );

  dac_phase_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i, .rst_ni, .load_i(tmr_load), .len_i(tmr_len), .last_o(tmr_last)
  );

  dac_byte_pack #(.CODE_W(CODE_W), .BUS_W(BUS_W)) u_pack (
    .code_i(pk_code), .gain_i(pk_gain), .rbuf_i(pk_rbuf), .hi_i(pk_hi), .byte_o(pk_byte)
  );
endmodule

// File: rtl/dac_wr_seq_chk.sv
module dac_wr_seq_chk #(
  parameter int unsigned ADDR_W  = 2,
  parameter int unsigned BUS_W   = 8,
  parameter int unsigned WRL_CYC = 2,
  parameter int unsigned GAP_CYC = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [BUS_W-1:0]  dac_data_o,
  input logic              dac_hben_o,
  input logic              dac_wr_no,
  input logic [ADDR_W-1:0] dac_addr_o,
  input logic              dac_sel_en_o,
  input logic              dac_ldac_no,
  input logic              dac_clr_no
);
  logic [7:0] low_run, high_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_run  <= '0;
      high_run <= 8'hff;
    end else begin
      low_run  <= dac_wr_no ? 8'd0 : low_run + 8'd1;
      if (!dac_wr_no)              high_run <= 8'd0;
      else if (high_run != 8'hff)  high_run <= high_run + 8'd1;
    end
  end

  // R3
  addr_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(dac_addr_o) |-> (!dac_sel_en_o && !$past(dac_sel_en_o)));
  // R3
  strobe_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dac_wr_no |-> dac_sel_en_o);
  // R4
  wr_low_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dac_wr_no) |-> (low_run == 8'(WRL_CYC)));
  // R4
  wr_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dac_wr_no) |-> (high_run >= 8'(GAP_CYC)));
  // R5
  setup_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dac_wr_no) |-> ($stable(dac_data_o) && $stable(dac_hben_o)));
  // R5
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dac_wr_no) |-> ($stable(dac_data_o) && $stable(dac_hben_o)));
  // R6
  ready_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  // R7
  load_after_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dac_ldac_no) |-> (dac_wr_no && $past(dac_wr_no)));
  // R9
  clr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dac_clr_no |-> (dac_wr_no && dac_ldac_no));
endmodule

bind dac_wr_seq dac_wr_seq_chk #(
  .ADDR_W(ADDR_W), .BUS_W(BUS_W), .WRL_CYC(WRL_CYC), .GAP_CYC(GAP_CYC)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .dac_data_o(dac_data_o), .dac_hben_o(dac_hben_o), .dac_wr_no(dac_wr_no),
  .dac_addr_o(dac_addr_o), .dac_sel_en_o(dac_sel_en_o), .dac_ldac_no(dac_ldac_no),
  .dac_clr_no(dac_clr_no)
);

// File: tb/tb_dac_wr_seq.sv
module tb_dac_wr_seq;
  localparam int CLK_NS   = 10;
  localparam int WRL_EXP  = (20 + CLK_NS - 1) / CLK_NS;
  localparam int GAP_EXP  = (50 + CLK_NS - 1) / CLK_NS;
  localparam int SU_EXP   = 1;
  localparam int LD_EXP   = (20 + CLK_NS - 1) / CLK_NS;
  localparam int CL_EXP   = (20 + CLK_NS - 1) / CLK_NS;
  localparam int BUSY_EXP = 1 + 2 * (SU_EXP + WRL_EXP + GAP_EXP);

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 0, req_gain_i = 0, req_rbuf_i = 0, commit_i = 0, clr_req_i = 0;
  logic [1:0]  req_chan_i = '0;
  logic [11:0] req_code_i = '0;
  logic        req_ready_o, dac_hben_o, dac_wr_no, dac_sel_en_o, dac_ldac_no, dac_clr_no;
  logic [7:0]  dac_data_o;
  logic [1:0]  dac_addr_o;

  always #(CLK_NS/2) clk = ~clk;

  dac_wr_seq dut (
    .clk_i(clk), .rst_ni, .req_valid_i, .req_ready_o, .req_chan_i, .req_code_i,
    .req_gain_i, .req_rbuf_i, .commit_i, .clr_req_i, .dac_data_o, .dac_hben_o,
    .dac_wr_no, .dac_addr_o, .dac_sel_en_o, .dac_ldac_no, .dac_clr_no
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_hi(input logic [11:0] c, input logic g, input logic b);
    return {b, g, 2'b00, c[11:8]};
  endfunction

  // strobe monitor
  logic [7:0] ev_data [0:1023];
  logic       ev_hben [0:1023];
  logic [1:0] ev_addr [0:1023];
  int ev_n = 0, ld_falls = 0, cl_falls = 0;
  int lo_run = 0, hi_run = 1000, ld_run = 0, cl_run = 0;
  logic wr_p = 1, ld_p = 1, cl_p = 1, en_p = 0, hb_p = 0, lo_hb = 0;
  logic [7:0] d_p = '0, lo_d = '0;
  logic [1:0] a_p = '0, lo_a = '0;

  always @(negedge clk) begin
    if (rst_ni) begin
      if (dac_addr_o != a_p)
        chk(!dac_sel_en_o && !en_p, "R3 addr moved with enable high", dac_sel_en_o, 0);
      if (!dac_wr_no) begin
        chk(dac_sel_en_o, "R3 enable during strobe", dac_sel_en_o, 1);
        if (wr_p) begin
          chk(hi_run >= GAP_EXP, "R4 gap", hi_run, GAP_EXP);
          chk(dac_data_o == d_p && dac_hben_o == hb_p, "R5 setup", dac_data_o, d_p);
          lo_d = dac_data_o; lo_hb = dac_hben_o; lo_a = dac_addr_o; lo_run = 1;
        end else begin
          chk(dac_data_o == lo_d && dac_hben_o == lo_hb && dac_addr_o == lo_a,
              "R5 stable low", dac_data_o, lo_d);
          lo_run++;
        end
      end else begin
        if (!wr_p) begin
          chk(lo_run == WRL_EXP, "R4 low width", lo_run, WRL_EXP);
          chk(dac_data_o == lo_d && dac_hben_o == lo_hb, "R5 hold", dac_data_o, lo_d);
          ev_data[ev_n] = lo_d; ev_hben[ev_n] = lo_hb; ev_addr[ev_n] = lo_a;
          ev_n++;
          hi_run = 1;
        end else hi_run++;
      end
      if (!dac_ldac_no) begin
        if (ld_p) begin
          ld_falls++; ld_run = 1;
          chk(wr_p && dac_wr_no, "R7 load after strobe", wr_p, 1);
        end else ld_run++;
      end else if (!ld_p) chk(ld_run == LD_EXP, "R7 load width", ld_run, LD_EXP);
      if (!dac_clr_no) begin
        if (cl_p) begin cl_falls++; cl_run = 1; end else cl_run++;
      end else if (!cl_p) chk(cl_run == CL_EXP, "R9 clear width", cl_run, CL_EXP);
    end
    wr_p = dac_wr_no; ld_p = dac_ldac_no; cl_p = dac_clr_no; en_p = dac_sel_en_o;
    hb_p = dac_hben_o; d_p = dac_data_o; a_p = dac_addr_o;
  end

  // inj: 0 none, 1 clear mid-write, 2 commit mid-write
  task automatic write_ch(input logic [1:0] ch, input logic [11:0] code,
                          input logic g, input logic b, input int inj);
    int base, busy, cl0;
    base = ev_n; cl0 = cl_falls;
    @(negedge clk);
    while (!req_ready_o) @(negedge clk);
    req_valid_i = 1; req_chan_i = ch; req_code_i = code; req_gain_i = g; req_rbuf_i = b;
    @(negedge clk);
    req_valid_i = 0; req_code_i = $urandom(); req_chan_i = 2'($urandom());
    busy = 0;
    while (!req_ready_o) begin
      busy++;
      clr_req_i = (inj == 1 && busy == 5);
      commit_i  = (inj == 2 && busy == 5);
      @(negedge clk);
    end
    clr_req_i = 0; commit_i = 0;
    if (inj != 2) chk(busy == BUSY_EXP, "R6 busy length", busy, BUSY_EXP);
    if (inj == 1) chk(cl_falls == cl0 && dac_clr_no, "R10 clear ignored", cl_falls - cl0, 0);
    chk(ev_n == base + 2, "R2 strobe count", ev_n - base, 2);
    chk(ev_data[base] == code[7:0] && !ev_hben[base] && ev_addr[base] == ch,
        "R2 low byte", ev_data[base], code[7:0]);
    chk(ev_data[base+1] == exp_hi(code, g, b) && ev_hben[base+1] && ev_addr[base+1] == ch,
        "R2 high byte", ev_data[base+1], exp_hi(code, g, b));
  endtask

  task automatic do_commit(input bit expect_load);
    int l0;
    l0 = ld_falls;
    @(negedge clk);
    while (!req_ready_o) @(negedge clk);
    commit_i = 1;
    @(negedge clk);
    commit_i = 0;
    chk(dac_ldac_no == !expect_load, expect_load ? "R7 load due" : "R8 no load",
        dac_ldac_no, !expect_load);
    repeat (4) @(negedge clk);
    chk(ld_falls - l0 == int'(expect_load), "R7 R8 load count", ld_falls - l0, expect_load);
  endtask

  task automatic do_clear();
    int c0;
    c0 = cl_falls;
    @(negedge clk);
    while (!req_ready_o) @(negedge clk);
    clr_req_i = 1;
    @(negedge clk);
    clr_req_i = 0;
    chk(!dac_clr_no, "R9 clear low first", dac_clr_no, 0);
    @(negedge clk);
    chk(!dac_clr_no, "R9 clear low second", dac_clr_no, 0);
    @(negedge clk);
    chk(dac_clr_no, "R9 clear released", dac_clr_no, 1);
    chk(cl_falls - c0 == 1, "R9 clear count", cl_falls - c0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
      $finish;
    end
  end

  initial begin
    int l0;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    chk(dac_wr_no && dac_ldac_no && dac_clr_no && !dac_sel_en_o && !dac_hben_o && req_ready_o,
        "R1 reset state", {dac_wr_no, dac_ldac_no, dac_clr_no, dac_sel_en_o, dac_hben_o, req_ready_o},
        6'b111001);
    rst_ni = 1;
    repeat (2) @(negedge clk);
    chk(req_ready_o && dac_wr_no, "R1 after release", req_ready_o, 1);

    // directed corners
    do_commit(0);                                   // R8 nothing written
    write_ch(2'd3, 12'hfff, 1'b1, 1'b1, 0);         // all ones
    write_ch(2'd0, 12'h000, 1'b0, 1'b0, 0);         // all zeros
    l0 = ld_falls;
    repeat (30) @(negedge clk);
    chk(ld_falls == l0, "R7 no load without commit", ld_falls - l0, 0);
    do_commit(1);
    do_commit(0);                                   // R8 after load
    write_ch(2'd1, 12'h5a3, 1'b1, 1'b0, 1);         // R10 clear mid-write
    do_commit(1);
    write_ch(2'd2, 12'h3c5, 1'b0, 1'b1, 2);         // R7 commit mid-write
    l0 = ld_falls;
    chk(l0 > 0, "R7 deferred load seen", l0, 1);
    do_commit(0);
    write_ch(2'd2, 12'h801, 1'b0, 1'b1, 0);
    do_clear();                                     // R9 discards pending
    do_commit(0);
    do_clear();

    // random batches
    for (int it = 0; it < 25; it++) begin
      int n;
      bit cleared;
      n = 1 + int'($urandom() % 4);
      cleared = 0;
      for (int k = 0; k < n; k++)
        write_ch(2'($urandom()), 12'($urandom()), 1'($urandom()), 1'($urandom()),
                 ($urandom() % 6 == 0) ? 1 : 0);
      if ($urandom() % 6 == 0) begin do_clear(); cleared = 1; end
      do_commit(!cleared);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule